// File: doc/BRIEF.md
# SD Host Command Register Front-End

This block is the register-side face of an SD card host. A processor talks to it through a small 32-bit word-addressed register bus. It stores the clock divider, enable and start settings, and it derives the pending flags. Through it the processor builds card commands one byte at a time, reads the card's reply back byte by byte, and moves four-byte data words to and from a byte-serial card data port. The physical bus signalling, CRC generation and clock division live elsewhere. The divider value is only held here.

When the sixth command byte arrives, the block splits the frame into an index, an argument and a check byte. It presents them on a valid/ready request port. The card side streams reply bytes into a buffer and ends with a done strobe that carries the reply length. The block then rewrites the readable reply view to suit the reply type. Command-register accesses stall while a request is outstanding. After an index-0 command, the next command byte is discarded, because it only serves as a dummy clocking byte. A card-present input gates all command and data traffic.

Top module: `sdhost_regfront`

## Requirements
- R1: After synchronous reset, the divider, enable, pending and start registers read as zero, and a command-register read returns 0x00.
- R2: Word offsets are 0 = divider (32 bits), 1 = enable (bits 3:0), 2 = pending, 3 = start (bits 1:0), 4 = command byte, 5 = data word. The byte address is the offset times 4, and the divider, enable and start registers read back what was written to their implemented bits.
- R3: Enable and pending use bit 0 for command transmit, bit 1 for command receive, bit 2 for data transmit and bit 3 for data receive. Pending bits 0 and 2 always read 0. Pending bits 1 and 3 equal enable bits 1 and 3, including right after a write to pending.
- R4: Each command write keeps only bits 7:0. The sixth byte issues a request with index = byte0 bits 5:0, argument = bytes 1..4 (byte1 most significant) and check byte = byte5. The request is held until accepted.
- R5: After a request with index 0 is issued, the next command write is discarded and does not advance the byte count.
- R6: Command reads step through the reply view. Position 0 holds the index, positions 1 onward hold the card bytes, and positions at or past the readable length read as 0x00. Once the read position has passed the length, it wraps to 0.
- R7: A 16-byte reply makes position 0 read 0x3F and sets the readable length to 17.
- R8: A 4-byte reply makes position 5 read 0x00 and sets the readable length to 6.
- R9: A data write sends four bytes on the transmit port, bits 31:24 first.
- R10: A data read collects four bytes from the receive port, and the first byte lands in bits 31:24.
- R11: With no card present, a command read returns 0xFF and a data read returns 0xFFFFFFFF. Command and data writes, and command reads, change nothing.
- R12: An access to any offset above 5 acknowledges with read data 0, has no effect, and raises the one-cycle error flag together with the acknowledge.
- R13: Every access gets a single-cycle acknowledge. Command accesses are held off while a request is outstanding, until the reply's done strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| card_present | input | 1 | High while a card is inserted |
| bus_req | input | 1 | Access request, held until acknowledge |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with acknowledge |
| bus_ack | output | 1 | One-cycle acknowledge |
| bus_err | output | 1 | Unmapped-offset flag, with acknowledge |
| cmd_req_valid | output | 1 | Command request valid |
| cmd_req_ready | input | 1 | Card side accepts request |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_crc | output | 8 | Command check byte |
| rsp_load_valid | input | 1 | Reply byte strobe |
| rsp_load_byte | input | 8 | Reply byte |
| rsp_done | input | 1 | Reply complete strobe |
| rsp_len | input | LEN_W | Reply length in bytes (0, 4 or 16) |
| dat_tx_valid | output | 1 | Transmit byte valid |
| dat_tx_byte | output | 8 | Transmit byte |
| dat_tx_ready | input | 1 | Transmit byte accepted |
| dat_rx_valid | input | 1 | Receive byte valid |
| dat_rx_byte | input | 8 | Receive byte |
| dat_rx_ready | output | 1 | Block accepts a receive byte |

## Verification
Command frames are built with junk in bits 31:8 and a distinct argument pattern, so a dropped mask or a swapped byte order gives a wrong request. Replies of 4, 16 and 0 bytes are each read past their end, which separates the short-reply zero byte, the 0x3F lead of the long reply and the wrap point. An index-0 frame followed by a throwaway byte and a well-formed frame shows whether the discard happens. A byte written with no card present, followed by a frame once the card is back, shows that the write count did not move and that the reply position was kept.

// File: rtl/sdrf_pkg.sv
package sdrf_pkg;

  typedef enum logic [2:0] {
    OFS_DIV   = 3'd0,
    OFS_EN    = 3'd1,
    OFS_PEND  = 3'd2,
    OFS_START = 3'd3,
    OFS_CMD   = 3'd4,
    OFS_DATA  = 3'd5
  } ofs_e;

  localparam int unsigned LAST_OFS = 5;

  // bit0 cmd tx, bit1 cmd rx, bit2 data tx, bit3 data rx
  localparam logic [3:0] RX_FLAG_MASK = 4'b1010;

  localparam logic [7:0] NO_CARD_BYTE = 8'hFF;
  localparam logic [7:0] LONG_LEAD    = 8'h3F;

  function automatic logic [3:0] rx_view(input logic [3:0] en);
    return en & RX_FLAG_MASK;
  endfunction

endpackage

// File: rtl/sdrf_cmd_frame.sv
module sdrf_cmd_frame #(
  parameter int FRAME_BYTES = 6,
  localparam int PW = $clog2(FRAME_BYTES),
  localparam int ARG_BYTES = FRAME_BYTES - 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_stb,
  input  logic [7:0]             wr_byte,
  input  logic                   rsp_done,
  output logic                   req_valid,
  input  logic                   req_ready,
  output logic [5:0]             idx,
  output logic [8*ARG_BYTES-1:0] arg,
  output logic [7:0]             crc,
  output logic                   busy
);

  localparam logic [PW-1:0] LAST = PW'(FRAME_BYTES - 1);

  logic [7:0]    frame [FRAME_BYTES];
  logic [PW-1:0] wptr;
  logic          skip_next;

  always_ff @(posedge clk) begin
    if (wr_stb && !skip_next) frame[wptr] <= wr_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      skip_next <= 1'b0;
      req_valid <= 1'b0;
      busy      <= 1'b0;
    end else begin
      if (req_valid && req_ready) req_valid <= 1'b0;
      if (rsp_done) busy <= 1'b0;
      if (wr_stb) begin
        if (skip_next) begin
          skip_next <= 1'b0;
        end else if (wptr == LAST) begin
          wptr      <= '0;
          req_valid <= 1'b1;
          busy      <= 1'b1;
          skip_next <= (frame[0][5:0] == 6'd0);
        end else begin
          wptr <= wptr + 1'b1;
        end
      end
    end
  end

  assign idx = frame[0][5:0];
  assign crc = frame[FRAME_BYTES-1];

  for (genvar g = 0; g < ARG_BYTES; g++) begin : g_arg
    assign arg[8*(ARG_BYTES-1-g) +: 8] = frame[g+1];
  end

  p_wptr_range_r4: assert property (@(posedge clk) disable iff (rst)
    wptr <= LAST) else $error("write pointer out of range");

  p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(arg) && $stable(idx) && $stable(crc))
    else $error("request dropped or changed before acceptance");

  p_no_write_busy_r13: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> !busy) else $error("command byte accepted during outstanding request");

endmodule

// File: rtl/sdrf_rsp_buf.sv
module sdrf_rsp_buf #(
  parameter int RSP_MAX   = 16,
  parameter int SHORT_LEN = 4,
  localparam int LEN_W = $clog2(RSP_MAX + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [5:0]       idx_in,
  input  logic             ld_valid,
  input  logic [7:0]       ld_byte,
  input  logic             done,
  input  logic [LEN_W-1:0] done_len,
  input  logic             rd_stb,
  output logic [7:0]       rd_byte
);
  import sdrf_pkg::*;

  localparam logic [LEN_W-1:0] MAXL   = LEN_W'(RSP_MAX);
  localparam logic [LEN_W-1:0] SHORTL = LEN_W'(SHORT_LEN);

  // entry 0 is never stored: the lead byte is computed on read
  logic [7:0]       mem [RSP_MAX+1];
  logic [LEN_W-1:0] ld_ptr;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] rptr;
  logic [5:0]       idx_q;
  logic             long_q;
  logic             short_q;

  always_ff @(posedge clk) begin
    if (ld_valid) mem[ld_ptr] <= ld_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_ptr  <= LEN_W'(1);
      len_q   <= '0;
      rptr    <= '0;
      idx_q   <= '0;
      long_q  <= 1'b0;
      short_q <= 1'b0;
    end else begin
      if (ld_valid && ld_ptr != MAXL) ld_ptr <= ld_ptr + 1'b1;
      if (done) begin
        ld_ptr  <= LEN_W'(1);
        rptr    <= '0;
        idx_q   <= idx_in;
        long_q  <= (done_len == MAXL);
        short_q <= (done_len == SHORTL);
        if (done_len == MAXL)        len_q <= MAXL + 1'b1;
        else if (done_len == SHORTL) len_q <= SHORTL + LEN_W'(2);
        else if (done_len > MAXL)    len_q <= MAXL;
        else                         len_q <= done_len;
      end else if (rd_stb) begin
        rptr <= (rptr >= len_q) ? '0 : rptr + 1'b1;
      end
    end
  end

  always_comb begin
    if (rptr >= len_q)                          rd_byte = 8'h00;
    else if (rptr == '0)                        rd_byte = long_q ? LONG_LEAD : {2'b00, idx_q};
    else if (short_q && rptr == SHORTL + 1'b1)  rd_byte = 8'h00;
    else                                        rd_byte = mem[rptr];
  end

  p_rptr_bound_r6: assert property (@(posedge clk) disable iff (rst)
    rptr <= len_q) else $error("read pointer past reply length");

  p_long_len_r7: assert property (@(posedge clk) disable iff (rst)
    long_q |-> len_q == MAXL + 1'b1) else $error("long reply length wrong");

  p_short_len_r8: assert property (@(posedge clk) disable iff (rst)
    short_q |-> len_q == SHORTL + LEN_W'(2)) else $error("short reply length wrong");

endmodule

// File: rtl/sdrf_word_serdes.sv
module sdrf_word_serdes #(
  parameter int BYTES = 4,
  localparam int DW = 8 * BYTES,
  localparam int CW = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_tx,
  input  logic          start_rx,
  input  logic [DW-1:0] wdata,
  output logic          tx_valid,
  output logic [7:0]    tx_byte,
  input  logic          tx_ready,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  output logic          rx_ready,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] word
);

  localparam logic [CW-1:0] LAST = CW'(BYTES - 1);

  logic          dir_tx;
  logic [CW-1:0] cnt;
  logic [DW-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      dir_tx <= 1'b0;
      cnt    <= '0;
      shreg  <= '0;
    end else begin
      done <= 1'b0;
      if (start_tx || start_rx) begin
        busy   <= 1'b1;
        dir_tx <= start_tx;
        cnt    <= '0;
        if (start_tx) shreg <= wdata;
      end else if (busy && ((dir_tx && tx_ready) || (!dir_tx && rx_valid))) begin
        shreg <= dir_tx ? {shreg[DW-9:0], 8'h00} : {shreg[DW-9:0], rx_byte};
        cnt   <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign tx_valid = busy && dir_tx;
  assign tx_byte  = shreg[DW-1 -: 8];
  assign rx_ready = busy && !dir_tx;
  assign word     = shreg;

  p_tx_hold_r9: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte)) else $error("tx byte not held");

  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy) else $error("done while still busy");

  p_start_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (start_tx || start_rx) |-> !busy && !done) else $error("start while busy");

endmodule

// File: rtl/sdhost_regfront.sv
module sdhost_regfront #(
  parameter int ADDR_W      = 8,
  parameter int FRAME_BYTES = 6,
  parameter int RSP_MAX     = 16,
  parameter int SHORT_LEN   = 4,
  parameter int DATA_BYTES  = 4,
  localparam int LEN_W = $clog2(RSP_MAX + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             card_present,
  input  logic             bus_req,
  input  logic             bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             bus_ack,
  output logic             bus_err,
  output logic             cmd_req_valid,
  input  logic             cmd_req_ready,
  output logic [5:0]       cmd_index,
  output logic [31:0]      cmd_arg,
  output logic [7:0]       cmd_crc,
  input  logic             rsp_load_valid,
  input  logic [7:0]       rsp_load_byte,
  input  logic             rsp_done,
  input  logic [LEN_W-1:0] rsp_len,
  output logic             dat_tx_valid,
  output logic [7:0]       dat_tx_byte,
  input  logic             dat_tx_ready,
  input  logic             dat_rx_valid,
  input  logic [7:0]       dat_rx_byte,
  output logic             dat_rx_ready
);
  import sdrf_pkg::*;

  localparam int WAW = ADDR_W - 2;

  logic [WAW-1:0] word;
  logic           unused_low;
  logic           bad_ofs;
  ofs_e           ofs;
  logic           is_cmd, is_dat;
  logic           accept, long_op;
  logic           cmd_busy;
  logic [7:0]     rsp_byte;
  logic           ser_busy, ser_done;
  logic [31:0]    ser_word;
  logic [31:0]    rd_mux;

  logic [31:0] div_q;
  logic [3:0]  en_q;
  logic [3:0]  pend_q;
  logic [1:0]  start_q;

  assign word       = bus_addr[ADDR_W-1:2];
  assign unused_low = ^bus_addr[1:0];
  assign bad_ofs    = (word > WAW'(LAST_OFS));
  assign ofs        = ofs_e'(word[2:0]);
  assign is_cmd     = !bad_ofs && (ofs == OFS_CMD);
  assign is_dat     = !bad_ofs && (ofs == OFS_DATA);

  assign accept  = bus_req && !bus_ack && !ser_busy && !ser_done
                   && !(is_cmd && card_present && cmd_busy);
  assign long_op = is_dat && card_present;

  sdrf_cmd_frame #(.FRAME_BYTES(FRAME_BYTES)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .wr_stb    (accept && bus_we && is_cmd && card_present),
    .wr_byte   (bus_wdata[7:0]),
    .rsp_done  (rsp_done),
    .req_valid (cmd_req_valid),
    .req_ready (cmd_req_ready),
    .idx       (cmd_index),
    .arg       (cmd_arg),
    .crc       (cmd_crc),
    .busy      (cmd_busy)
  );

  sdrf_rsp_buf #(.RSP_MAX(RSP_MAX), .SHORT_LEN(SHORT_LEN)) u_rsp (
    .clk      (clk),
    .rst      (rst),
    .idx_in   (cmd_index),
    .ld_valid (rsp_load_valid),
    .ld_byte  (rsp_load_byte),
    .done     (rsp_done),
    .done_len (rsp_len),
    .rd_stb   (accept && !bus_we && is_cmd && card_present),
    .rd_byte  (rsp_byte)
  );

  sdrf_word_serdes #(.BYTES(DATA_BYTES)) u_ser (
    .clk      (clk),
    .rst      (rst),
    .start_tx (accept && bus_we && long_op),
    .start_rx (accept && !bus_we && long_op),
    .wdata    (bus_wdata),
    .tx_valid (dat_tx_valid),
    .tx_byte  (dat_tx_byte),
    .tx_ready (dat_tx_ready),
    .rx_valid (dat_rx_valid),
    .rx_byte  (dat_rx_byte),
    .rx_ready (dat_rx_ready),
    .busy     (ser_busy),
    .done     (ser_done),
    .word     (ser_word)
  );

  always_comb begin
    rd_mux = '0;
    if (!bad_ofs) begin
      case (ofs)
        OFS_DIV:   rd_mux = div_q;
        OFS_EN:    rd_mux = {28'd0, en_q};
        OFS_PEND:  rd_mux = {28'd0, pend_q};
        OFS_START: rd_mux = {30'd0, start_q};
        OFS_CMD:   rd_mux = {24'd0, card_present ? rsp_byte : NO_CARD_BYTE};
        OFS_DATA:  rd_mux = '1;
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q     <= '0;
      en_q      <= '0;
      pend_q    <= '0;
      start_q   <= '0;
      bus_ack   <= 1'b0;
      bus_err   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack <= 1'b0;
      bus_err <= 1'b0;
      if (ser_done) begin
        bus_ack   <= 1'b1;
        bus_rdata <= ser_word;
      end else if (accept && !long_op) begin
        bus_ack   <= 1'b1;
        bus_err   <= bad_ofs;
        bus_rdata <= rd_mux;
        if (bus_we && !bad_ofs) begin
          case (ofs)
            OFS_DIV:   div_q <= bus_wdata;
            OFS_EN: begin
              en_q   <= bus_wdata[3:0];
              pend_q <= rx_view(bus_wdata[3:0]);
            end
            OFS_PEND:  pend_q <= rx_view(en_q);
            OFS_START: start_q <= bus_wdata[1:0];
            default: ;
          endcase
        end
      end
    end
  end

  p_pend_tx_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !pend_q[0] && !pend_q[2]) else $error("tx pending bit set");

  p_pend_cmd_rx_r3: assert property (@(posedge clk) disable iff (rst)
    en_q[1] |-> pend_q[1]) else $error("cmd rx pending missing");

  p_pend_dat_rx_r3: assert property (@(posedge clk) disable iff (rst)
    en_q[3] |-> pend_q[3]) else $error("data rx pending missing");

  p_ack_pulse_r13: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack) else $error("acknowledge longer than one cycle");

  p_err_with_ack_r12: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> bus_ack) else $error("error flag without acknowledge");

endmodule

// File: tb/sim_sdhost_regfront.sv
module sim_sdhost_regfront;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        card_present = 1'b1;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ack, bus_err;
  logic        cmd_req_valid, cmd_req_ready;
  logic [5:0]  cmd_index;
  logic [31:0] cmd_arg;
  logic [7:0]  cmd_crc;
  logic        rsp_load_valid, rsp_done;
  logic [7:0]  rsp_load_byte;
  logic [4:0]  rsp_len;
  logic        dat_tx_valid, dat_rx_valid, dat_rx_ready;
  logic        dat_tx_ready = 1'b1;
  logic [7:0]  dat_tx_byte, dat_rx_byte;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  sdhost_regfront u0 (
    .clk(clk), .rst(rst), .card_present(card_present),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err),
    .cmd_req_valid(cmd_req_valid), .cmd_req_ready(cmd_req_ready),
    .cmd_index(cmd_index), .cmd_arg(cmd_arg), .cmd_crc(cmd_crc),
    .rsp_load_valid(rsp_load_valid), .rsp_load_byte(rsp_load_byte),
    .rsp_done(rsp_done), .rsp_len(rsp_len),
    .dat_tx_valid(dat_tx_valid), .dat_tx_byte(dat_tx_byte), .dat_tx_ready(dat_tx_ready),
    .dat_rx_valid(dat_rx_valid), .dat_rx_byte(dat_rx_byte), .dat_rx_ready(dat_rx_ready)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct {bit rd; logic [31:0] data; bit err; string tag;} bus_exp_t;
  typedef struct {logic [5:0] idx; logic [31:0] arg; logic [7:0] crc; int rlen; logic [7:0] rbase; string tag;} req_exp_t;

  bus_exp_t   bus_q[$];
  req_exp_t   req_q[$];
  logic [7:0] tx_q[$];
  logic [7:0] rx_src[$];

  // driver: pushes the expected outcome, then performs the access
  task automatic bus_op(input bit we, input logic [7:0] addr, input logic [31:0] wd,
                        input logic [31:0] exp, input bit experr, input string tag,
                        output int waited);
    bus_exp_t e;
    e.rd = !we; e.data = exp; e.err = experr; e.tag = tag;
    bus_q.push_back(e);
    bus_req = 1'b1; bus_we = we; bus_addr = addr; bus_wdata = wd;
    waited = 0;
    do begin @(negedge clk); waited++; end while (!bus_ack);
    @(posedge clk); #1;
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wr(input logic [7:0] addr, input logic [31:0] d, input string tag);
    int w;
    bus_op(1'b1, addr, d, 32'h0, 1'b0, tag, w);
  endtask

  task automatic rd(input logic [7:0] addr, input logic [31:0] exp, input string tag);
    int w;
    bus_op(1'b0, addr, 32'h0, exp, 1'b0, tag, w);
  endtask

  task automatic expect_req(input logic [5:0] i, input logic [31:0] a, input logic [7:0] c,
                            input int rlen, input logic [7:0] rbase, input string tag);
    req_exp_t r;
    r.idx = i; r.arg = a; r.crc = c; r.rlen = rlen; r.rbase = rbase; r.tag = tag;
    req_q.push_back(r);
  endtask

  // bus monitor
  always @(negedge clk) begin : mon_bus
    bus_exp_t e;
    if (!rst && bus_ack) begin
      if (bus_q.size() == 0) chk(1'b0, "R13 unexpected ack", 32'h1, 32'h0);
      else begin
        e = bus_q.pop_front();
        chk(bus_err == e.err, {e.tag, " err"}, {31'd0, bus_err}, {31'd0, e.err});
        if (e.rd) chk(bus_rdata == e.data, e.tag, bus_rdata, e.data);
      end
    end
  end

  // transmit monitor
  always @(negedge clk) begin : mon_tx
    logic [7:0] b;
    if (!rst && dat_tx_valid) begin
      if (tx_q.size() == 0) chk(1'b0, "R11 unexpected tx byte", {24'd0, dat_tx_byte}, 32'h0);
      else begin
        b = tx_q.pop_front();
        chk(dat_tx_byte == b, "R9 tx byte", {24'd0, dat_tx_byte}, {24'd0, b});
      end
    end
  end

  // receive source
  initial begin
    dat_rx_valid = 1'b0; dat_rx_byte = '0;
    forever begin
      @(posedge clk); #1;
      if (rx_src.size() > 0 && dat_rx_ready) begin
        dat_rx_valid = 1'b1;
        dat_rx_byte  = rx_src.pop_front();
      end else dat_rx_valid = 1'b0;
    end
  end

  // card model: checks each request and answers it
  initial begin
    req_exp_t r;
    cmd_req_ready = 1'b0; rsp_load_valid = 1'b0; rsp_load_byte = '0;
    rsp_done = 1'b0; rsp_len = '0;
    forever begin
      @(negedge clk);
      if (!rst && cmd_req_valid) begin
        if (req_q.size() == 0) begin
          chk(1'b0, "R11 unexpected request", {26'd0, cmd_index}, 32'h0);
          r.rlen = 0; r.rbase = 8'h00;
        end else begin
          r = req_q.pop_front();
          chk(cmd_index == r.idx, {r.tag, " index"}, {26'd0, cmd_index}, {26'd0, r.idx});
          chk(cmd_arg == r.arg, {r.tag, " argument"}, cmd_arg, r.arg);
          chk(cmd_crc == r.crc, {r.tag, " check byte"}, {24'd0, cmd_crc}, {24'd0, r.crc});
        end
        @(posedge clk); #1 cmd_req_ready = 1'b1;
        @(posedge clk); #1 cmd_req_ready = 1'b0;
        for (int i = 0; i < r.rlen; i++) begin
          rsp_load_valid = 1'b1;
          rsp_load_byte  = r.rbase + 8'(i);
          @(posedge clk); #1;
        end
        rsp_load_valid = 1'b0;
        rsp_done = 1'b1;
        rsp_len  = 5'(r.rlen);
        @(posedge clk); #1 rsp_done = 1'b0;
      end
    end
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL R13 watchdog: actual=hung expected=complete");
    finish_run();
  end

  initial begin
    int w;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state
    rd(8'h00, 32'h0, "R1 divider");
    rd(8'h04, 32'h0, "R1 enable");
    rd(8'h08, 32'h0, "R1 pending");
    rd(8'h0C, 32'h0, "R1 start");
    rd(8'h10, 32'h0, "R1 cmd byte");

    // R2: map and read-back
    wr(8'h00, 32'h1234ABCD, "R2");
    rd(8'h00, 32'h1234ABCD, "R2 divider");
    wr(8'h0C, 32'hFFFFFFFF, "R2");
    rd(8'h0C, 32'h3, "R2 start");
    wr(8'h04, 32'hFFFFFFFF, "R2");
    rd(8'h04, 32'hF, "R2 enable");

    // R3: pending follows receive enables
    rd(8'h08, 32'hA, "R3 all enabled");
    wr(8'h08, 32'hF, "R3");
    rd(8'h08, 32'hA, "R3 clear while enabled");
    wr(8'h04, 32'h5, "R3");
    rd(8'h08, 32'h0, "R3 tx only");
    wr(8'h04, 32'h2, "R3");
    wr(8'h08, 32'h2, "R3");
    rd(8'h08, 32'h2, "R3 cmd rx");

    // R4 / R6 / R8 / R13: frame with junk upper bits, 4-byte reply
    expect_req(6'h11, 32'h12345678, 8'h87, 4, 8'hA0, "R4");
    wr(8'h10, 32'hFFFFFF51, "R4");
    wr(8'h10, 32'hA5A5A512, "R4");
    wr(8'h10, 32'h00000034, "R4");
    wr(8'h10, 32'h5A5A5A56, "R4");
    wr(8'h10, 32'h00000078, "R4");
    wr(8'h10, 32'hCCCCCC87, "R4");
    bus_op(1'b0, 8'h10, 32'h0, 32'h11, 1'b0, "R6 index", w);
    chk(w >= 4, "R13 stall", w, 32'd4);
    rd(8'h10, 32'hA0, "R6 byte1");
    rd(8'h10, 32'hA1, "R6 byte2");
    rd(8'h10, 32'hA2, "R6 byte3");
    rd(8'h10, 32'hA3, "R6 byte4");
    rd(8'h10, 32'h00, "R8 zero byte");
    rd(8'h10, 32'h00, "R6 past end");
    rd(8'h10, 32'h11, "R6 wrap");

    // R7: long reply
    expect_req(6'h02, 32'h0, 8'h4D, 16, 8'h10, "R7");
    wr(8'h10, 32'h42, "R7"); wr(8'h10, 32'h00, "R7"); wr(8'h10, 32'h00, "R7");
    wr(8'h10, 32'h00, "R7"); wr(8'h10, 32'h00, "R7"); wr(8'h10, 32'h4D, "R7");
    rd(8'h10, 32'h3F, "R7 lead");
    for (int i = 0; i < 16; i++) rd(8'h10, 32'h10 + i, "R7 body");
    rd(8'h10, 32'h00, "R7 past end");
    rd(8'h10, 32'h3F, "R7 wrap");

    // R5: index 0, then a discarded byte
    expect_req(6'h00, 32'h0, 8'h95, 0, 8'h00, "R5 first");
    wr(8'h10, 32'h40, "R5"); wr(8'h10, 32'h00, "R5"); wr(8'h10, 32'h00, "R5");
    wr(8'h10, 32'h00, "R5"); wr(8'h10, 32'h00, "R5"); wr(8'h10, 32'h95, "R5");
    rd(8'h10, 32'h00, "R6 empty reply");
    wr(8'h10, 32'hAB, "R5 dummy");
    expect_req(6'h08, 32'h000001AA, 8'h87, 4, 8'h01, "R5 second");
    wr(8'h10, 32'h48, "R5"); wr(8'h10, 32'h00, "R5"); wr(8'h10, 32'h00, "R5");
    wr(8'h10, 32'h01, "R5"); wr(8'h10, 32'hAA, "R5"); wr(8'h10, 32'h87, "R5");
    rd(8'h10, 32'h08, "R5 index");
    rd(8'h10, 32'h01, "R5 byte1");

    // R9 / R10: data word
    tx_q.push_back(8'h11); tx_q.push_back(8'h22); tx_q.push_back(8'h33); tx_q.push_back(8'h44);
    wr(8'h14, 32'h11223344, "R9");
    rx_src.push_back(8'hDE); rx_src.push_back(8'hAD); rx_src.push_back(8'hBE); rx_src.push_back(8'hEF);
    rd(8'h14, 32'hDEADBEEF, "R10");

    // R11: card absent
    card_present = 1'b0;
    rd(8'h10, 32'hFF, "R11 cmd");
    rd(8'h14, 32'hFFFFFFFF, "R11 data");
    wr(8'h14, 32'h55667788, "R11");
    for (int i = 0; i < 6; i++) wr(8'h10, 32'h41, "R11");
    repeat (4) @(posedge clk);
    #1 card_present = 1'b1;
    rd(8'h10, 32'h02, "R11 position kept");
    expect_req(6'h0D, 32'h0, 8'h01, 0, 8'h00, "R11 count kept");
    wr(8'h10, 32'h4D, "R11"); wr(8'h10, 32'h00, "R11"); wr(8'h10, 32'h00, "R11");
    wr(8'h10, 32'h00, "R11"); wr(8'h10, 32'h00, "R11"); wr(8'h10, 32'h01, "R11");
    rd(8'h10, 32'h00, "R11 reply");

    // R12: unmapped offsets
    bus_op(1'b0, 8'h18, 32'h0, 32'h0, 1'b1, "R12 read", w);
    bus_op(1'b1, 8'h1C, 32'hFFFFFFFF, 32'h0, 1'b1, "R12 write", w);
    bus_op(1'b0, 8'h3C, 32'h0, 32'h0, 1'b1, "R12 high", w);
    rd(8'h00, 32'h1234ABCD, "R12 divider kept");
    rd(8'h04, 32'h2, "R12 enable kept");

    repeat (10) @(posedge clk);
    chk(bus_q.size() == 0, "R13 pending acks", bus_q.size(), 0);
    chk(req_q.size() == 0, "R4 pending requests", req_q.size(), 0);
    chk(tx_q.size() == 0, "R9 pending tx bytes", tx_q.size(), 0);
    chk(rx_src.size() == 0, "R10 pending rx bytes", rx_src.size(), 0);
    finish_run();
  end

endmodule